// File: doc/BRIEF.md
# SPI Memory Address-Width Probe

This block is a boot-time SPI master sequencer. It works out how many address bytes an attached serial EEPROM or flash part expects before that part starts returning data. A single start pulse lowers one dedicated chip-select output and sends a read command. The block then keeps clocking zero bytes on MOSI and watches what comes back on MISO. The MISO and select lines are pulled up, so a part that is still taking in address bits leaves MISO floating and the block reads all ones.

The first byte that differs from 0xFF shows that the device has moved on to data. The count of zero bytes sent up to that point gives the address width: 8, 16, 24 or 32 bits. When detection succeeds, or when four address bytes have gone by with nothing but ones, the block releases chip select, pulses `done` for one cycle, and presents a 2-bit width code and an error flag. Both stay valid until the next start. The SPI clock rate comes from a half-period divider parameter whose reset default is 0x85. Streaming the boot image after detection is handled elsewhere.

Top module: `spiWidthProbe`

## Requirements
- R1: While reset is held and right after it is released, `spiCsN` is 1, `spiSck` is 0, `spiMosi` is 0, and `done`, `busy`, `error` and `widthCode` are all 0.
- R2: A `start` pulse seen while idle drives `spiCsN` low and `busy` high in the next cycle. `spiCsN` then stays low without a break until the probe ends. Whenever `busy` is 0, `spiCsN` is 1.
- R3: `spiSck` is low whenever `spiCsN` is high. The following intervals each last exactly HALF_DIV+1 clock cycles: every SCK high phase, every SCK low phase, the gap from the select falling to the first rising edge, and the gap from the last falling edge to the select rising. The reset default of HALF_DIV is 0x85, which gives 134 cycles.
- R4: MOSI carries the command byte 0x03 first, MSB first (SPI mode 0), followed only by 0x00 bytes. Each byte takes eight SCK rising edges, and MOSI never changes while SCK is high.
- R5: The byte received during the first zero byte after the command is never inspected. A device that already returns data there is still reported with code 0.
- R6: Bytes are numbered 0 for the command, 1 for the first zero byte, and so on. MISO is sampled on SCK rising edges. Every byte from number 2 onward is inspected. The first inspected byte that is not 0xFF ends the probe with `error` at 0 and `widthCode` equal to its number minus 2 (0 = 8-bit, 1 = 16-bit, 2 = 24-bit, 3 = 32-bit).
- R7: A received byte that differs from 0xFF in a single bit (0x7F or 0xFE) counts as detection, just as 0x00 or 0xA5 does.
- R8: If byte 5 is still 0xFF, the probe ends with `error` at 1 and `widthCode` at 0.
- R9: A probe of n bytes lasts (HALF_DIV+1)*(1+16n) cycles from the accepting edge to the first cycle that shows `done`. `done` is high for exactly one cycle, with `spiCsN` already high in that cycle. `error` and `widthCode` keep their values until the next start.
- R10: A `start` pulse while `busy` is 1, including the cycle that shows `done`, has no effect. The running probe keeps its length and result, and `spiCsN` stays high after it ends.
- R11: When byte 5 carries data, detection takes priority over the error limit: `widthCode` is 3 and `error` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe (accepted only while idle) |
| spiCsN | output | 1 | Active-low device select |
| spiSck | output | 1 | SPI clock, idles low |
| spiMosi | output | 1 | Master-out serial data |
| spiMiso | input | 1 | Master-in serial data, pulled high |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | No device detected within four address bytes |
| widthCode | output | CODE_W (2) | Detected address width code |

## Verification
The delicate collision is on byte 5. The same byte-end decision can either report a 32-bit device or declare that no device answered. The bench provokes this with a device model that starts returning data exactly at byte 5, and expects code 3 with the error flag low. It contrasts that case with a model that never answers, which must give the error and a six-byte transaction length. A second collision, a start request landing in the cycle that shows `done`, is driven directly. It is judged by `busy` and the select line staying inactive afterwards.

// File: rtl/spi_probe_pkg.sv
package spi_probe_pkg;

  // Strobes issued by the sequencer to the shift/count datapath
  typedef struct packed {
    logic loadCmd;     // start of probe: command byte, clear counters and result
    logic divRestart;  // reload the half-period counter
    logic sampleMiso;  // SCK rising edge: shift MISO in
    logic shiftOut;    // SCK falling edge inside a byte: next MOSI bit
    logic nextByte;    // byte boundary: load a zero byte, advance byte index
    logic latchWidth;  // detection: capture width code
    logic latchError;  // limit reached with no data
  } probeStrobes_t;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_LEAD,
    PS_HIGH,
    PS_LOW,
    PS_TRAIL,
    PS_FINISH
  } probeState_t;

endpackage

// File: rtl/probeDatapath.sv
module probeDatapath
  import spi_probe_pkg::*;
#(
  parameter int DIV_W          = 8,
  parameter int HALF_DIV       = 'h85,
  parameter int MAX_ADDR_BYTES = 4,
  parameter logic [7:0] READ_CMD = 8'h03,
  parameter int IDX_W          = 3,
  parameter int CODE_W         = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  probeStrobes_t     strobes,
  input  logic              spiMiso,
  output logic              tick,
  output logic              lastBit,
  output logic              rxIdle,
  output logic              inspectByte,
  output logic              finalByte,
  output logic              spiMosi,
  output logic [CODE_W-1:0] widthCode,
  output logic              error
);

  localparam int BYTE_W      = 8;
  localparam int BIT_W       = $clog2(BYTE_W);
  localparam int FIRST_CHECK = 2;
  localparam int LAST_IDX    = MAX_ADDR_BYTES + 1;
  localparam logic [DIV_W-1:0]  DIV_LOAD  = DIV_W'(HALF_DIV);
  localparam logic [BYTE_W-1:0] FILL_BYTE = '0;
  localparam logic [BYTE_W-1:0] IDLE_BUS  = '1;

  logic [DIV_W-1:0]  divCnt;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic [BIT_W-1:0]  bitCnt;
  logic [IDX_W-1:0]  byteIdx;
  logic [CODE_W-1:0] widthReg;
  logic              errReg;

  // Half-period timer shared by every SCK phase and the select guard gaps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   divCnt <= DIV_LOAD;
    else if (strobes.divRestart) divCnt <= DIV_LOAD;
    else if (divCnt != '0)       divCnt <= divCnt - 1'b1;
  end

  assign tick = (divCnt == '0);

  // Transmit shifter: command first, zero fill afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 txShift <= '0;
    else if (strobes.loadCmd)  txShift <= READ_CMD;
    else if (strobes.nextByte) txShift <= FILL_BYTE;
    else if (strobes.shiftOut) txShift <= {txShift[BYTE_W-2:0], 1'b0};
  end

  assign spiMosi = txShift[BYTE_W-1];

  // Receive shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   rxShift <= '0;
    else if (strobes.sampleMiso) rxShift <= {rxShift[BYTE_W-2:0], spiMiso};
  end

  assign rxIdle = (rxShift == IDLE_BUS);

  // Bit and byte position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (strobes.loadCmd) begin
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (strobes.nextByte) begin
      bitCnt  <= '0;
      byteIdx <= byteIdx + 1'b1;
    end else if (strobes.shiftOut) begin
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  assign lastBit     = (bitCnt == BIT_W'(BYTE_W - 1));
  assign inspectByte = (byteIdx >= IDX_W'(FIRST_CHECK));
  assign finalByte   = (byteIdx == IDX_W'(LAST_IDX));

  // Result registers, held until the next probe starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthReg <= '0;
      errReg   <= 1'b0;
    end else if (strobes.loadCmd) begin
      widthReg <= '0;
      errReg   <= 1'b0;
    end else if (strobes.latchWidth) begin
      widthReg <= CODE_W'(byteIdx - IDX_W'(FIRST_CHECK));
      errReg   <= 1'b0;
    end else if (strobes.latchError) begin
      widthReg <= '0;
      errReg   <= 1'b1;
    end
  end

  assign widthCode = widthReg;
  assign error     = errReg;

endmodule

// File: rtl/probeCtrl.sv
module probeCtrl
  import spi_probe_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          tick,
  input  logic          lastBit,
  input  logic          rxIdle,
  input  logic          inspectByte,
  input  logic          finalByte,
  output probeStrobes_t strobes,
  output logic          spiCsN,
  output logic          spiSck,
  output logic          busy,
  output logic          done
);

  probeState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PS_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      PS_IDLE: begin
        if (start) begin
          strobes.loadCmd    = 1'b1;
          strobes.divRestart = 1'b1;
          nextState          = PS_LEAD;
        end
      end
      PS_LEAD, PS_LOW: begin
        if (tick) begin
          strobes.sampleMiso = 1'b1;
          strobes.divRestart = 1'b1;
          nextState          = PS_HIGH;
        end
      end
      PS_HIGH: begin
        if (tick) begin
          strobes.divRestart = 1'b1;
          if (!lastBit) begin
            strobes.shiftOut = 1'b1;
            nextState        = PS_LOW;
          end else if (inspectByte && !rxIdle) begin
            strobes.latchWidth = 1'b1;
            nextState          = PS_TRAIL;
          end else if (finalByte) begin
            strobes.latchError = 1'b1;
            nextState          = PS_TRAIL;
          end else begin
            strobes.nextByte = 1'b1;
            nextState        = PS_LOW;
          end
        end
      end
      PS_TRAIL: begin
        if (tick) nextState = PS_FINISH;
      end
      PS_FINISH: nextState = PS_IDLE;
      default:   nextState = PS_IDLE;
    endcase
  end

  assign spiCsN = (state == PS_IDLE) || (state == PS_FINISH);
  assign spiSck = (state == PS_HIGH);
  assign busy   = (state != PS_IDLE);
  assign done   = (state == PS_FINISH);

endmodule

// File: rtl/spiWidthProbe.sv
module spiWidthProbe
  import spi_probe_pkg::*;
#(
  parameter int DIV_W          = 8,
  parameter int HALF_DIV       = 'h85,
  parameter int MAX_ADDR_BYTES = 4,
  parameter logic [7:0] READ_CMD = 8'h03,
  localparam int CODE_W        = $clog2(MAX_ADDR_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              spiCsN,
  output logic              spiSck,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [CODE_W-1:0] widthCode
);

  localparam int IDX_W = $clog2(MAX_ADDR_BYTES + 2);

  probeStrobes_t strobes;
  logic tick, lastBit, rxIdle, inspectByte, finalByte;

  probeCtrl i_probeCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .tick        (tick),
    .lastBit     (lastBit),
    .rxIdle      (rxIdle),
    .inspectByte (inspectByte),
    .finalByte   (finalByte),
    .strobes     (strobes),
    .spiCsN      (spiCsN),
    .spiSck      (spiSck),
    .busy        (busy),
    .done        (done)
  );

  probeDatapath #(
    .DIV_W          (DIV_W),
    .HALF_DIV       (HALF_DIV),
    .MAX_ADDR_BYTES (MAX_ADDR_BYTES),
    .READ_CMD       (READ_CMD),
    .IDX_W          (IDX_W),
    .CODE_W         (CODE_W)
  ) i_probeDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .spiMiso     (spiMiso),
    .tick        (tick),
    .lastBit     (lastBit),
    .rxIdle      (rxIdle),
    .inspectByte (inspectByte),
    .finalByte   (finalByte),
    .spiMosi     (spiMosi),
    .widthCode   (widthCode),
    .error       (error)
  );

endmodule

// File: rtl/probeChecker.sv
module probeChecker #(
  parameter int CODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              spiCsN,
  input logic              spiSck,
  input logic              spiMosi,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [CODE_W-1:0] widthCode
);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> spiCsN);

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiSck |-> $stable(spiMosi));

  // R2
  idle_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiCsN);

  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R2
  select_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !spiCsN);

  // R8
  error_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> (widthCode == '0));

endmodule

bind spiWidthProbe probeChecker #(.CODE_W(CODE_W)) i_probeChecker (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .spiCsN    (spiCsN),
  .spiSck    (spiSck),
  .spiMosi   (spiMosi),
  .busy      (busy),
  .done      (done),
  .error     (error),
  .widthCode (widthCode)
);

// File: tb/test_spiWidthProbe.sv
`timescale 1ns/1ps
module test_spiWidthProbe;

  localparam int HALF  = 2;
  localparam int PHASE = HALF + 1;
  localparam int DFLT_PHASE = 'h85 + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic startD = 1'b0;
  always #10 clk = ~clk;

  logic csN, sck, mosi, miso, busy, done, err;
  logic [1:0] code;
  logic csD, sckD, mosiD, busyD, doneD, errD;
  logic [1:0] codeD;

  int checks = 0;
  int fails  = 0;

  // Device model: data appears from byte devWidth+1 on
  int devWidth = 5;
  logic [7:0] devData = 8'h00;
  int fallCnt = 0;
  logic prevSck = 1'b0;

  always @(posedge clk) begin
    prevSck <= sck;
    if (csN) fallCnt <= 0;
    else if (prevSck && !sck) fallCnt <= fallCnt + 1;
  end

  wire [2:0] bitSel = 3'(7 - (fallCnt % 8));
  assign miso = (!csN && (fallCnt / 8) >= devWidth + 1) ? devData[bitSel] : 1'b1;

  spiWidthProbe #(.HALF_DIV(HALF)) i_spiWidthProbe (
    .clk(clk), .rstN(rstN), .start(start), .spiCsN(csN), .spiSck(sck),
    .spiMosi(mosi), .spiMiso(miso), .busy(busy), .done(done),
    .error(err), .widthCode(code)
  );

  spiWidthProbe i_spiWidthProbe_dflt (
    .clk(clk), .rstN(rstN), .start(startD), .spiCsN(csD), .spiSck(sckD),
    .spiMosi(mosiD), .spiMiso(1'b1), .busy(busyD), .done(doneD),
    .error(errD), .widthCode(codeD)
  );

  // Port monitor: MOSI bytes, MOSI stability, phase lengths
  logic csMon = 1'b1, sckMon = 1'b0, mosiMon = 1'b0;
  logic [7:0] capShift = '0;
  logic [7:0] capBytes [8];
  int capBits = 0, byteCnt = 0, runLen = 0;
  bit mosiBad = 0, phaseBad = 0;

  always @(negedge clk) begin
    if (!csN && csMon) begin
      capBits = 0; byteCnt = 0; runLen = 0; mosiBad = 0; phaseBad = 0;
    end
    if (!csN) begin
      if (sck && !sckMon) begin
        capShift = {capShift[6:0], mosi};
        capBits++;
        if (capBits % 8 == 0 && byteCnt < 8) begin
          capBytes[byteCnt] = capShift;
          byteCnt++;
        end
      end
      if (sck && sckMon && mosi != mosiMon) mosiBad = 1;
      if (csMon || sck == sckMon) runLen++;
      else begin
        if (runLen != PHASE) phaseBad = 1;
        runLen = 1;
      end
    end else if (!csMon) begin
      if (runLen != PHASE) phaseBad = 1;
    end
    csMon = csN; sckMon = sck; mosiMon = mosi;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Run one probe against a device of width w (0..5) returning data d
  task automatic runProbe(input int w, input logic [7:0] d,
                          input int midStart, input bit endStart);
    int cnt = 0;
    int b, nBytes, expCode;
    bit expErr, cmdOk;
    devWidth = w; devData = d;
    b = (w + 1 < 2) ? 2 : w + 1;
    expErr  = (b > 5);
    nBytes  = expErr ? 6 : b + 1;
    expCode = expErr ? 0 : b - 2;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    check(!csN && busy, "R2", "select low after start", int'(csN), 0);
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      start = (midStart != 0 && cnt == midStart);
    end while (!done && cnt < 20000);
    start = endStart;
    check(cnt == PHASE * (1 + 16 * nBytes), "R9", "probe length", cnt,
          PHASE * (1 + 16 * nBytes));
    if (w == 4) check(code == 2'd3 && !err, "R11", "final-byte detection code", int'(code), 3);
    else if (w == 0) check(int'(code) == expCode && !err, "R5", "first zero byte ignored", int'(code), expCode);
    else if (expErr) check(err && code == 2'd0, "R8", "no-device error", int'(err), 1);
    else check(int'(code) == expCode && !err, "R6", "width code", int'(code), expCode);
    if (d == 8'h7F || d == 8'hFE)
      check(!err || expErr, "R7", "single-bit detection", int'(err), int'(expErr));
    @(negedge clk) start = 1'b0;
    check(!done && !busy && csN, "R9", "done single cycle, idle after", int'(done), 0);
    if (endStart) check(!busy && csN, "R10", "start in done cycle ignored", int'(busy), 0);
    cmdOk = (byteCnt == nBytes) && (capBytes[0] == 8'h03);
    for (int i = 1; i < nBytes && i < 8; i++) if (capBytes[i] != 8'h00) cmdOk = 0;
    check(cmdOk, "R4", "MOSI byte stream", byteCnt, nBytes);
    check(!mosiBad, "R4", "MOSI stable while SCK high", int'(mosiBad), 0);
    check(!phaseBad, "R3", "SCK phase lengths", int'(phaseBad), 0);
    repeat (3) @(negedge clk);
    check(int'(code) == expCode && err == expErr && csN, "R9", "result held",
          int'(code), expCode);
    if (midStart != 0) check(cnt == PHASE * (1 + 16 * nBytes), "R10", "mid-probe start ignored",
                             cnt, PHASE * (1 + 16 * nBytes));
  endtask

  logic [7:0] pats [4] = '{8'h00, 8'h7F, 8'hFE, 8'hA5};

  initial begin
    repeat (3) @(negedge clk);
    check(csN && !sck && !mosi && !done && !busy && !err && code == 0,
          "R1", "outputs in reset", int'(csN), 1);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check(csN && !sck && !mosi && !done && !busy && !err && code == 0 && csD && !sckD,
          "R1", "outputs after reset", int'(busy), 0);

    for (int w = 0; w <= 5; w++)
      for (int p = 0; p < 4; p++)
        runProbe(w, pats[p], 0, 0);

    runProbe(2, 8'h3C, 37, 0);
    runProbe(4, 8'h00, 0, 1);
    runProbe(5, 8'h00, 61, 1);

    // Default divider: 0x85 -> 134-cycle phases
    begin
      int cnt = 0;
      @(negedge clk) startD = 1'b1;
      @(posedge clk);
      @(negedge clk) startD = 1'b0;
      while (!sckD && cnt < 1000) begin @(posedge clk); cnt++; @(negedge clk); end
      check(cnt == DFLT_PHASE, "R3", "default lead gap", cnt, DFLT_PHASE);
      cnt = 0;
      while (sckD && cnt < 1000) begin @(posedge clk); cnt++; @(negedge clk); end
      check(cnt == DFLT_PHASE, "R3", "default high phase", cnt, DFLT_PHASE);
      cnt = 0;
      while (!doneD && cnt < 20000) begin @(posedge clk); cnt++; @(negedge clk); end
      check(errD && codeD == 0, "R8", "default instance no device", int'(errD), 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

endmodule